// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. A translation starts when the walker is idle and a request arrives with the address, whether the access is a write, and whether it comes from user mode. The walker then reads the directory entry and, for small pages, the table entry through a single-beat memory port with a request/acknowledge handshake. It writes entries back when their accessed or dirty flags need setting. It reports the physical address, the page size, the combined user and write rights, and a fault indication.

Paging enable, large-page enable, the A20 address mask and the table base come from the surrounding core and are sampled when a request is accepted. Deciding whether the access is actually allowed, and assembling an error code, is left to a downstream checker. That checker receives the echoed access type and user flag along with the rights. Entries use these bit positions: present 0, writable 1, user 2, accessed 5, dirty 6, page size 7, large-page reserved 21.

Top module: `page_walker`

## Requirements
- R1: With paging disabled at acceptance, `rsp_valid` rises one cycle after acceptance and no memory access is made. The result is a 4 KB page with the user and write rights both set. The physical address is the virtual address with its bits 31:12 ANDed with the A20 mask and its bits 11:0 passed unchanged. Address bits 39:32 are zero.
- R2: The first read of a walk is at the address formed as follows: clear the low 12 bits of the base, add four times virtual bits 31:22, then AND the sum with the A20 mask.
- R3: On the 4 KB path, the table entry is read at the address formed as follows: clear the low 12 bits of the directory entry, add four times virtual bits 21:12, then AND the sum with the A20 mask. The result address is the masked table-entry bits 31:12 followed by virtual bits 11:0.
- R4: A directory or table entry with bit 0 clear ends the walk with `rsp_fault` high and `rsp_rsvd` low. An entry read with bit 0 clear is never written.
- R5: A directory entry with bit 7 set, read while large pages are enabled, maps a 4 MB page. Result bits 39:32 come from entry bits 20:13, and bits 31:22 come from the masked entry. Bits 21:0 come from the virtual address, and `rsp_large` is high. If entry bit 21 is set, the walk instead faults with `rsp_rsvd` high and no write. With large pages disabled, bit 7 is ignored and the 4 KB path is taken.
- R6: On the 4 KB path, a present directory entry with bit 5 clear is written back with bit 5 set before the table entry is read.
- R7: The reported user right (bit 2) and write right (bit 1) are the AND of those bits in the directory and table entries. For a 4 MB page they come from the directory entry alone.
- R8: The final entry is written back only if bit 5 is clear, or if the access is a write and bit 6 is clear. The value written has bit 5 set and, for writes, bit 6 set.
- R9: `rsp_write_ok` is low whenever the final entry is not dirty (bit 6 clear) after the walk.
- R10: `req_ready` is low from acceptance until the response cycle. Requests presented in that time are ignored and produce no response.
- R11: A memory request keeps its address, direction and write data stable until it is acknowledged.
- R12: `rsp_valid` is a one-cycle pulse. On a fault the address and both rights read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| cfg_paging_en | input | 1 | Paging enabled |
| cfg_large_en | input | 1 | 4 MB pages enabled |
| cfg_a20_mask | input | 32 | Mask applied to table and frame addresses |
| cfg_base | input | 32 | Page directory base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Entry value written back |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Entry value, valid with `mem_ack` |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_paddr | output | 32+HI_BITS | Physical address |
| rsp_large | output | 1 | 4 MB page |
| rsp_user_ok | output | 1 | Combined user right |
| rsp_write_ok | output | 1 | Combined write right, dirty-qualified |
| rsp_fault | output | 1 | Walk faulted |
| rsp_rsvd | output | 1 | Fault was a reserved-bit fault |
| rsp_write | output | 1 | Echo of the access type |
| rsp_user | output | 1 | Echo of the user flag |

## Verification
The bench builds the walker with its default `HI_BITS` of 8, so the full 40-bit result is exercised. With that width, every directory-entry bit from 13 to 20 lands in a distinct result bit, and the reserved bit 21 sits just above that field. The memory model acknowledges after random delays, so the hold rule and write-back ordering are tested under stalls. Random walks alternate the A20 mask with bit 20 cleared, which moves table reads and frames to aliased addresses that the reference model recomputes on its own.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int ENT_P   = 0;
  localparam int ENT_W   = 1;
  localparam int ENT_U   = 2;
  localparam int ENT_A   = 5;
  localparam int ENT_D   = 6;
  localparam int ENT_PS  = 7;
  localparam int ENT_RSV = 21;
  localparam int HI_LSB  = 13;

  typedef enum logic [2:0] {
    W_IDLE, W_DIR_RD, W_DIR_WB, W_TAB_RD, W_TAB_WB, W_DONE
  } walk_st_t;

  // directory slot: 4 KB aligned base plus index from va[31:22]
  function automatic logic [31:0] dir_slot(input logic [31:0] base,
                                           input logic [31:0] va,
                                           input logic [31:0] mask);
    return ({base[31:12], 12'h000} + {20'h0, va[31:22], 2'b00}) & mask;
  endfunction

  // table slot: frame of directory entry plus index from va[21:12]
  function automatic logic [31:0] tab_slot(input logic [31:0] dent,
                                           input logic [31:0] va,
                                           input logic [31:0] mask);
    return ({dent[31:12], 12'h000} + {20'h0, va[21:12], 2'b00}) & mask;
  endfunction

  function automatic logic needs_touch(input logic [31:0] e, input logic wr);
    return !e[ENT_A] || (wr && !e[ENT_D]);
  endfunction

  function automatic logic [31:0] touch(input logic [31:0] e, input logic wr);
    logic [31:0] r;
    r = e;
    r[ENT_A] = 1'b1;
    if (wr) r[ENT_D] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [31:0] base,
  input  logic [31:0] req_va,
  input  logic [31:0] req_mask,
  input  logic [31:0] dir_ent,
  input  logic [31:0] walk_va,
  input  logic [31:0] walk_mask,
  output logic [31:0] dir_addr,
  output logic [31:0] tab_addr
);
  assign dir_addr = dir_slot(base, req_va, req_mask);
  assign tab_addr = tab_slot(dir_ent, walk_va, walk_mask);
endmodule

// File: rtl/ptw_result.sv
`timescale 1ns/1ps
module ptw_result
  import ptw_pkg::*;
#(
  parameter int HI_BITS = 8,
  localparam int PA_W = 32 + HI_BITS
) (
  input  logic            off,
  input  logic            big,
  input  logic            fault,
  input  logic [31:0]     va,
  input  logic [31:0]     mask,
  input  logic [1:0]      dir_uw,   // {user, write} of directory entry
  input  logic [31:0]     leaf,
  output logic [PA_W-1:0] paddr,
  output logic            user_ok,
  output logic            write_ok
);
  logic [31:0] frame_keep;
  logic [31:0] src;

  always_comb begin
    frame_keep = big ? 32'hFFC0_0000 : 32'hFFFF_F000;
    src        = off ? va : leaf;
    paddr      = '0;
    user_ok    = 1'b0;
    write_ok   = 1'b0;
    if (!fault) begin
      paddr[31:0] = (src & mask & frame_keep) | (va & ~frame_keep);
      if (off) begin
        user_ok  = 1'b1;
        write_ok = 1'b1;
      end else begin
        if (big) paddr[PA_W-1:32] = leaf[HI_LSB +: HI_BITS];
        user_ok  = dir_uw[1] & leaf[ENT_U];
        write_ok = dir_uw[0] & leaf[ENT_W] & leaf[ENT_D];
      end
    end
  end
endmodule

// File: rtl/page_walker.sv
`timescale 1ns/1ps
module page_walker
  import ptw_pkg::*;
#(
  parameter int HI_BITS = 8,
  localparam int PA_W = 32 + HI_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_vaddr,
  input  logic            req_write,
  input  logic            req_user,
  input  logic            cfg_paging_en,
  input  logic            cfg_large_en,
  input  logic [31:0]     cfg_a20_mask,
  input  logic [31:0]     cfg_base,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_large,
  output logic            rsp_user_ok,
  output logic            rsp_write_ok,
  output logic            rsp_fault,
  output logic            rsp_rsvd,
  output logic            rsp_write,
  output logic            rsp_user
);
  walk_st_t    st;
  logic [31:0] va_q, mask_q, dir_q, leaf_q, slot_q, wb_q;
  logic        wr_q, usr_q, big_en_q, last_q, off_q, big_q, flt_q, rsv_q;

  // named internal events
  logic        accept, xfer;
  logic [31:0] dir_addr, tab_addr, tab_src;

  assign accept    = req_valid && req_ready;
  assign xfer      = mem_req && mem_ack;
  assign req_ready = (st == W_IDLE);
  assign mem_req   = (st == W_DIR_RD) || (st == W_DIR_WB) ||
                     (st == W_TAB_RD) || (st == W_TAB_WB);
  assign mem_we    = (st == W_DIR_WB) || (st == W_TAB_WB);
  assign mem_addr  = slot_q;
  assign mem_wdata = wb_q;
  assign tab_src   = (st == W_DIR_RD) ? mem_rdata : dir_q;

  ptw_addr_gen u_addr (
    .base     (cfg_base),
    .req_va   (req_vaddr),
    .req_mask (cfg_a20_mask),
    .dir_ent  (tab_src),
    .walk_va  (va_q),
    .walk_mask(mask_q),
    .dir_addr (dir_addr),
    .tab_addr (tab_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE;
      va_q <= '0; mask_q <= '0; dir_q <= '0; leaf_q <= '0;
      slot_q <= '0; wb_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0; big_en_q <= 1'b0; last_q <= 1'b0;
      off_q <= 1'b0; big_q <= 1'b0; flt_q <= 1'b0; rsv_q <= 1'b0;
    end else begin
      case (st)
        W_IDLE: if (accept) begin
          va_q     <= req_vaddr;
          wr_q     <= req_write;
          usr_q    <= req_user;
          big_en_q <= cfg_large_en;
          mask_q   <= cfg_a20_mask;
          off_q    <= !cfg_paging_en;
          big_q    <= 1'b0;
          flt_q    <= 1'b0;
          rsv_q    <= 1'b0;
          slot_q   <= dir_addr;
          st       <= cfg_paging_en ? W_DIR_RD : W_DONE;
        end
        W_DIR_RD: if (xfer) begin
          dir_q <= mem_rdata;
          if (!mem_rdata[ENT_P]) begin
            flt_q <= 1'b1;
            st    <= W_DONE;
          end else if (mem_rdata[ENT_PS] && big_en_q) begin
            big_q <= 1'b1;
            if (mem_rdata[ENT_RSV]) begin
              flt_q <= 1'b1;
              rsv_q <= 1'b1;
              st    <= W_DONE;
            end else if (needs_touch(mem_rdata, wr_q)) begin
              wb_q   <= touch(mem_rdata, wr_q);
              last_q <= 1'b1;
              st     <= W_DIR_WB;
            end else begin
              leaf_q <= mem_rdata;
              st     <= W_DONE;
            end
          end else if (!mem_rdata[ENT_A]) begin
            wb_q   <= touch(mem_rdata, 1'b0);
            last_q <= 1'b0;
            st     <= W_DIR_WB;
          end else begin
            slot_q <= tab_addr;
            st     <= W_TAB_RD;
          end
        end
        W_DIR_WB: if (xfer) begin
          if (last_q) begin
            leaf_q <= wb_q;
            st     <= W_DONE;
          end else begin
            slot_q <= tab_addr;
            st     <= W_TAB_RD;
          end
        end
        W_TAB_RD: if (xfer) begin
          if (!mem_rdata[ENT_P]) begin
            flt_q <= 1'b1;
            st    <= W_DONE;
          end else if (needs_touch(mem_rdata, wr_q)) begin
            wb_q   <= touch(mem_rdata, wr_q);
            last_q <= 1'b1;
            st     <= W_TAB_WB;
          end else begin
            leaf_q <= mem_rdata;
            st     <= W_DONE;
          end
        end
        W_TAB_WB: if (xfer) begin
          leaf_q <= wb_q;
          st     <= W_DONE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  ptw_result #(.HI_BITS(HI_BITS)) u_res (
    .off     (off_q),
    .big     (big_q),
    .fault   (flt_q),
    .va      (va_q),
    .mask    (mask_q),
    .dir_uw  ({dir_q[ENT_U], dir_q[ENT_W]}),
    .leaf    (leaf_q),
    .paddr   (rsp_paddr),
    .user_ok (rsp_user_ok),
    .write_ok(rsp_write_ok)
  );

  assign rsp_valid = (st == W_DONE);
  assign rsp_large = big_q && !flt_q;
  assign rsp_fault = flt_q;
  assign rsp_rsvd  = rsv_q;
  assign rsp_write = wr_q;
  assign rsp_user  = usr_q;

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  // R1
  nopage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_paging_en) |=> (rsp_valid && !mem_req));
  // R8
  wb_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[ENT_A] && mem_wdata[ENT_P]));
  // R12
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R5
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rsvd) |-> (rsp_fault && !rsp_large && !rsp_user_ok));
endmodule

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;
  localparam int HB = 8;
  localparam logic [31:0] BASE = 32'h0001_0ABC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = '0;
  logic cfg_paging_en = 1, cfg_large_en = 1;
  logic [31:0] cfg_a20_mask = '1, cfg_base = BASE;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic req_ready, rsp_valid, rsp_large, rsp_user_ok, rsp_write_ok;
  logic rsp_fault, rsp_rsvd, rsp_write, rsp_user;
  logic [39:0] rsp_paddr;

  page_walker #(.HI_BITS(HB)) dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [logic [31:0]];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_log [int];
  logic [31:0] lat_a, lat_d;
  logic lat_we;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      if (lat_we) begin mem[lat_a] = lat_d; wr_cnt++; end
      else begin rd_log[rd_cnt] = lat_a; rd_cnt++; end
      mem_ack = 1'b0;
    end else if (mem_req && ($urandom_range(0, 2) != 0)) begin
      lat_a = mem_addr; lat_we = mem_we; lat_d = mem_wdata;
      mem_rdata = rdm(mem_addr);
      mem_ack = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // reference model state
  logic [39:0] e_pa;
  logic e_flt, e_rsv, e_large, e_uok, e_wok, e_hasd, e_hast;
  logic [31:0] e_da, e_ta, e_dv, e_tv;
  int e_nwr, e_nrd;

  task automatic predict(input logic [31:0] va, input logic wr, input logic pg,
                         input logic big, input logic [31:0] mask);
    logic [31:0] d, t, dn, tn;
    e_flt = 0; e_rsv = 0; e_large = 0; e_uok = 0; e_wok = 0; e_pa = '0;
    e_nwr = 0; e_nrd = 0; e_hasd = 0; e_hast = 0; e_da = 0; e_ta = 0; e_dv = 0; e_tv = 0;
    if (!pg) begin
      e_pa = {8'h00, ((va & mask) & 32'hFFFF_F000) | (va & 32'h0000_0FFF)};
      e_uok = 1; e_wok = 1;
      return;
    end
    e_da = ((BASE & 32'hFFFF_F000) | ((va >> 20) & 32'h0000_0FFC)) & mask;
    d = rdm(e_da); e_dv = d; e_hasd = 1; e_nrd = 1;
    if (!d[0]) begin e_flt = 1; return; end
    if (d[7] && big) begin
      if (d[21]) begin e_flt = 1; e_rsv = 1; return; end
      dn = d | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (!d[5] || (wr && !d[6])) begin e_dv = dn; e_nwr = 1; end else dn = d;
      e_large = 1;
      e_pa = {d[20:13], (dn & mask & 32'hFFC0_0000) | (va & 32'h003F_FFFF)};
      e_uok = d[2]; e_wok = d[1] & dn[6];
      return;
    end
    if (!d[5]) begin e_dv = d | 32'h20; e_nwr = 1; end
    e_ta = ((d & 32'hFFFF_F000) | ((va >> 10) & 32'h0000_0FFC)) & mask;
    t = rdm(e_ta); e_tv = t; e_hast = 1; e_nrd = 2;
    if (!t[0]) begin e_flt = 1; return; end
    tn = t | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (!t[5] || (wr && !t[6])) begin e_tv = tn; e_nwr++; end else tn = t;
    e_pa = {8'h00, (tn & mask & 32'hFFFF_F000) | (va & 32'h0000_0FFF)};
    e_uok = d[2] & t[2]; e_wok = d[1] & t[1] & tn[6];
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr,
                      input logic pg, input logic big, input logic [31:0] mask,
                      input bit poke);
    int r0, w0, n;
    string pt;
    predict(va, wr, pg, big, mask);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; cfg_paging_en = pg;
    cfg_large_en = big; cfg_a20_mask = mask; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (!pg) chk(rsp_valid === 1'b1, "R1 response one cycle after acceptance", rsp_valid, 1);
    n = 0;
    while (!rsp_valid && n < 300) begin
      if (poke) begin
        chk(req_ready === 1'b0, "R10 busy while walking", req_ready, 0);
        req_vaddr = va ^ 32'h8040_1000; req_valid = 1;
      end
      @(negedge clk); n++;
    end
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R12 response arrives", rsp_valid, 1);
    pt = !pg ? "R1 paddr" : (e_large ? "R5 paddr" : "R3 paddr");
    chk(rsp_fault === e_flt, "R4 fault", rsp_fault, e_flt);
    chk(rsp_rsvd === e_rsv, "R5 reserved fault", rsp_rsvd, e_rsv);
    chk(rsp_large === e_large, "R5 large", rsp_large, e_large);
    chk(rsp_paddr === e_pa, pt, rsp_paddr, e_pa);
    chk(rsp_user_ok === e_uok, "R7 user right", rsp_user_ok, e_uok);
    chk(rsp_write_ok === e_wok, "R9 write right", rsp_write_ok, e_wok);
    chk(rsp_write === wr && rsp_user === usr, "R12 echo", {rsp_write, rsp_user}, {wr, usr});
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12 single pulse", rsp_valid, 0);
    @(negedge clk);
    chk(rd_cnt - r0 == e_nrd, "R2 read count", rd_cnt - r0, e_nrd);
    chk(wr_cnt - w0 == e_nwr, "R8 write count", wr_cnt - w0, e_nwr);
    if (e_nrd >= 1) chk(rd_log[r0] === e_da, "R2 directory address", rd_log[r0], e_da);
    if (e_nrd >= 2) chk(rd_log[r0 + 1] === e_ta, "R3 table address", rd_log[r0 + 1], e_ta);
    if (e_hasd) chk(rdm(e_da) === e_dv, "R6 directory after walk", rdm(e_da), e_dv);
    if (e_hast) chk(rdm(e_ta) === e_tv, "R8 table after walk", rdm(e_ta), e_tv);
    if (poke) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R10 ignored request gives no response", rsp_valid, 0);
      end
    end
  endtask

  // place entries where the reference model says they are read
  task automatic place(input logic [31:0] va, input logic [31:0] d, input logic [31:0] t,
                       input logic [31:0] mask);
    logic [31:0] da, ta;
    da = ((BASE & 32'hFFFF_F000) | ((va >> 20) & 32'h0000_0FFC)) & mask;
    mem[da] = d;
    ta = ((d & 32'hFFFF_F000) | ((va >> 10) & 32'h0000_0FFC)) & mask;
    if (ta != da) mem[ta] = t;
  endtask

  initial begin
    #(150000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] va, d, t, m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0,
        "R12 reset state", {req_ready, rsp_valid, mem_req}, 3'b100);

    // R1 paging off, aliased mask
    walk(32'h1234_5678, 1, 1, 0, 1, 32'hFFEF_FFFF, 0);
    // R4 directory not present
    place(32'h0040_2000, 32'h0012_3066, 32'h0, '1);
    walk(32'h0040_2000, 0, 0, 1, 1, '1, 0);
    // R5 large page with reserved bit 21
    place(32'h0080_0000, 32'h0C20_00E7, 32'h0, '1);
    walk(32'h0080_0000, 0, 1, 1, 1, '1, 0);
    // R5 large page with high bits, write sets accessed and dirty
    place(32'h00C3_4567, 32'h0C00_0000 | (32'hA5 << 13) | 32'h87, 32'h0, '1);
    walk(32'h00C3_4567, 1, 1, 1, 1, '1, 0);
    // R5 page-size bit ignored when large pages are off; R6 directory accessed set
    place(32'h0100_5123, 32'h0013_4087, 32'h0055_5007, '1);
    walk(32'h0100_5123, 0, 0, 1, 0, '1, 0);
    // R9 clean final entry read: write right withheld
    place(32'h0140_6ABC, 32'h0014_5027, 32'h0066_6023, '1);
    walk(32'h0140_6ABC, 0, 1, 1, 1, '1, 0);
    // R8 write to accessed clean entry sets dirty
    place(32'h0180_7000, 32'h0015_6027, 32'h0077_7027, '1);
    walk(32'h0180_7000, 1, 0, 1, 1, '1, 0);
    // R4 table entry not present
    place(32'h01C0_8000, 32'h0016_7027, 32'h0088_8066, '1);
    walk(32'h01C0_8000, 1, 1, 1, 1, '1, 0);
    // R8 already accessed and dirty: no write; R7 user right cleared by table
    place(32'h0200_9000, 32'h0017_8027, 32'h0099_9063, '1);
    walk(32'h0200_9000, 1, 1, 1, 1, '1, 0);
    // R10 requests while busy are ignored
    place(32'h0240_A000, 32'h0018_9007, 32'h00AA_A003, '1);
    walk(32'h0240_A000, 0, 1, 1, 1, '1, 1);

    for (int k = 0; k < 300; k++) begin
      va = $urandom;
      m  = ($urandom_range(0, 3) == 0) ? 32'hFFEF_FFFF : 32'hFFFF_FFFF;
      d  = $urandom;
      d[31:12] = 20'h00120 + 20'($urandom_range(0, 199));
      d[0]  = ($urandom_range(0, 9) != 0);
      d[21] = ($urandom_range(0, 4) == 0);
      t  = $urandom;
      t[0]  = ($urandom_range(0, 9) != 0);
      place(va, d, t, m);
      walk(va, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)), m, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule